// File: doc/BRIEF.md
# Sampler-Side Read-Only Line Cache

This block is a small read-only cache placed between one texture sampler and the next cache level down. The sampler presents a byte address with a valid/ready handshake and gets back the complete 256-bit line that contains that address. Lines live in a fully associative array, so any line address can occupy any entry. A lookup compares the request tag against every valid entry in parallel. On a miss the block asks the lower level for the aligned line, waits for it, and then writes it into the array and hands it to the sampler in the same cycle.

Two paths bypass the array. A request can carry an uncached flag. Such a request always goes to the lower level and leaves the array unchanged, even when a matching line is resident. Each request also names a surface. A surface stays uncacheable until its producer signals that it has finished writing it. Until then, reads of that surface behave like uncached reads. A flush input invalidates the whole array in one cycle so that a rewritten surface is not served from stale lines. The cache never holds modified data, so it has no write-back path.

Top module: `tex_l1_cache`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and every entry is invalid, so the first cacheable read of any line misses.
- R2: A cacheable request that hits raises `rsp_valid` for one cycle, one cycle after acceptance. It returns the stored line and issues no lower-level request.
- R3: A miss raises `mem_req_valid` for exactly the cycle after acceptance. `mem_req_addr` carries the request address with its low 5 bits cleared. `req_ready` stays 0 from the cycle after acceptance until the cycle after the fill arrives.
- R4: In the cycle after `mem_rsp_valid` is seen, `rsp_valid` is 1 and `rsp_data` equals the returned line. For a cacheable miss the line is also allocated, so the next read of that line hits.
- R5: A request with `req_uncached` set always fetches from the lower level. It never hits, and it never allocates or replaces an entry.
- R6: Reads of a surface whose write-complete pulse has not yet arrived (`surf_done_valid` with `surf_done_id`) fetch from the lower level and do not allocate. After the pulse, the surface stays cacheable until reset.
- R7: Any set of up to `CACHE_BYTES*8/256` distinct lines (256 by default) can be resident at once, whatever their addresses.
- R8: Fills go to the lowest-numbered invalid entry. When every entry is valid, victims are chosen round-robin, starting at entry 0 after reset.
- R9: A one-cycle `flush` pulse invalidates every entry, so the next cacheable read of any line misses. Flush leaves the surface write-complete state unchanged.
- R10: Byte offsets within a line share one entry. A read at any offset of a resident line hits and returns the whole 256-bit line.
- R11: At most one miss is outstanding. `mem_req_valid` is never high on two consecutive cycles, and no new request is accepted until the fill returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Sampler request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | 32 | Byte address of the request |
| req_uncached | input | 1 | Force a lower-level read with no lookup and no fill |
| req_surf | input | 3 | Surface identifier of the request |
| rsp_valid | output | 1 | Line response present (one cycle) |
| rsp_data | output | 256 | Full line returned to the sampler |
| mem_req_valid | output | 1 | Line request to the lower level (one-cycle pulse) |
| mem_req_addr | output | 32 | Line-aligned address of the lower-level request |
| mem_rsp_valid | input | 1 | Lower level returns the requested line |
| mem_rsp_data | input | 256 | Line data from the lower level |
| surf_done_valid | input | 1 | Write-complete pulse for a surface |
| surf_done_id | input | 3 | Surface that has finished being written |
| flush | input | 1 | Invalidate every entry |

## Verification
A hit produces its response one cycle after the accepting edge. A miss produces `mem_req_valid` one cycle after acceptance and its response one cycle after the edge that samples `mem_rsp_valid`. `req_ready` returns in that same cycle. Every bench task drives inputs at the falling edge and samples at the next falling edge after the edge at which each result is due. The bench also checks `mem_req_valid` and `req_ready` in the wait cycle between request and fill, so an extra request or an early ready shows up. The lower-level model returns a version-tagged pattern for each line. A stale hit, a lost allocation or an allocation that should not have happened therefore shows up as a data mismatch or as an unexpected lower-level request.

// File: rtl/tex_l1_pkg.sv
// Package: shared types for the sampler-side read-only line cache.
// Assumes: nothing beyond IEEE 1800-2017.
package tex_l1_pkg;

    // Miss handling sequence of the controller.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // accepting requests
        ST_ISSUE = 2'd1,   // line request pulse to the lower level
        ST_WAIT  = 2'd2    // waiting for the line to return
    } fill_state_e;

    // Number of lines held for a given capacity and line size.
    function automatic int unsigned line_count(input int unsigned cap_bytes,
                                               input int unsigned line_bits);
        return (cap_bytes * 8) / line_bits;
    endfunction

endpackage

// File: rtl/tl1_tag_cam.sv
// Module: tl1_tag_cam
// Fully associative tag store with per-entry valid bits. It compares a lookup
// tag against every valid entry in parallel and picks fill victims: the
// lowest invalid entry first, otherwise a round-robin pointer.
// Assumes: the caller never allocates a tag that is already resident, so at
// most one entry can match. Flush takes priority over a same-cycle allocation.
module tl1_tag_cam #(
    parameter int LINES = 256,
    parameter int TAG_W = 27,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic [TAG_W-1:0] lookup_tag_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] hit_idx_o,
    input  logic             alloc_en_i,
    input  logic [TAG_W-1:0] alloc_tag_i,
    output logic [IDX_W-1:0] alloc_idx_o
);

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] hit_vec;
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] first_inv;
    logic             any_inv;
    logic             do_alloc;

    // Per-entry comparators, one per line.
    for (genvar g = 0; g < LINES; g++) begin : g_cmp
        assign hit_vec[g] = valid_q[g] && (tag_q[g] == lookup_tag_i);
    end

    // Encode the (at most one-hot) match vector to an entry index.
    always_comb begin
        hit_idx_o = '0;
        for (int i = 0; i < LINES; i++) begin
            if (hit_vec[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
        end
    end

    assign hit_o = |hit_vec;

    // Find the lowest-numbered invalid entry.
    always_comb begin
        first_inv = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (!valid_q[i]) first_inv = IDX_W'(i);
        end
    end

    assign any_inv     = ~&valid_q;
    assign alloc_idx_o = any_inv ? first_inv : rr_q;
    assign do_alloc    = alloc_en_i && !flush_i;

    // Valid bits: clear on reset or flush, set on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush_i) begin
            valid_q <= '0;
        end else if (do_alloc) begin
            valid_q[alloc_idx_o] <= 1'b1;
        end
    end

    // Round-robin pointer: advances only when a valid entry is replaced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (do_alloc && !any_inv) begin
            rr_q <= (rr_q == IDX_W'(LINES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // Tag storage: written on allocation only; gated by the valid bits.
    always_ff @(posedge clk) begin
        if (do_alloc) tag_q[alloc_idx_o] <= alloc_tag_i;
    end

    AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec)); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_i) |-> (valid_q == '0)); // R9

    AST_RR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rr_q) |-> $past(&valid_q)); // R8

endmodule

// File: rtl/tl1_line_store.sv
// Module: tl1_line_store
// Line data array with one write port for fills and one asynchronous read
// port for hits.
// Assumes: the read index is meaningful only when the caller saw a hit.
module tl1_line_store #(
    parameter int LINES  = 256,
    parameter int LINE_W = 256,
    parameter int IDX_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [LINE_W-1:0] wr_data_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [LINE_W-1:0] rd_data_o
);

    logic [LINE_W-1:0] data_q [LINES];

    // Write one full line on a fill.
    always_ff @(posedge clk) begin
        if (wr_en_i) data_q[wr_idx_i] <= wr_data_i;
    end

    // Combinational read for the hit path; the controller registers it.
    assign rd_data_o = data_q[rd_idx_i];

endmodule

// File: rtl/tl1_surf_gate.sv
// Module: tl1_surf_gate
// Per-surface write-complete flags. A surface becomes cacheable once its
// write-complete pulse is seen and stays so until reset.
// Assumes: the producer pulses the surface id once writing has finished.
module tl1_surf_gate #(
    parameter int NUM_SURF = 8,
    parameter int SURF_W   = $clog2(NUM_SURF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_valid_i,
    input  logic [SURF_W-1:0] done_id_i,
    input  logic [SURF_W-1:0] query_id_i,
    output logic              ready_o
);

    logic [NUM_SURF-1:0] ready_q;

    // Set the flag of a surface when its write-complete pulse arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= '0;
        end else if (done_valid_i) begin
            ready_q[done_id_i] <= 1'b1;
        end
    end

    assign ready_o = ready_q[query_id_i];

    AST_SEM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_q & $past(ready_q)) == $past(ready_q))); // R6

endmodule

// File: rtl/tex_l1_cache.sv
// Module: tex_l1_cache
// Read-only fully associative line cache for one sampler. Hits answer one
// cycle after acceptance. A miss issues one line request, waits for the
// fill, writes it (when cacheable) and forwards it in the same cycle.
// Uncached requests and reads of surfaces not yet marked complete bypass
// both lookup and allocation.
// Assumes: one requester; the lower level answers every line request
// exactly once; LINE_BITS is a power of two.
module tex_l1_cache
    import tex_l1_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int LINE_BITS   = 256,
    parameter int CACHE_BYTES = 8192,
    parameter int NUM_SURF    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic [ADDR_W-1:0]                req_addr,
    input  logic                             req_uncached,
    input  logic [$clog2(NUM_SURF)-1:0]      req_surf,
    output logic                             rsp_valid,
    output logic [LINE_BITS-1:0]             rsp_data,
    output logic                             mem_req_valid,
    output logic [ADDR_W-1:0]                mem_req_addr,
    input  logic                             mem_rsp_valid,
    input  logic [LINE_BITS-1:0]             mem_rsp_data,
    input  logic                             surf_done_valid,
    input  logic [$clog2(NUM_SURF)-1:0]      surf_done_id,
    input  logic                             flush
);

    localparam int OFF_W  = $clog2(LINE_BITS / 8);
    localparam int LINES  = line_count(CACHE_BYTES, LINE_BITS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int SURF_W = $clog2(NUM_SURF);

    fill_state_e          state_q;
    logic [TAG_W-1:0]     pend_tag_q;
    logic                 pend_alloc_q;
    logic                 rsp_valid_q;
    logic [LINE_BITS-1:0] rsp_data_q;

    logic [TAG_W-1:0]     req_tag;
    logic                 surf_ok;
    logic                 cacheable;
    logic                 cam_hit;
    logic [IDX_W-1:0]     hit_idx;
    logic [IDX_W-1:0]     fill_idx;
    logic [LINE_BITS-1:0] store_rd;
    logic                 accept;
    logic                 take_hit;
    logic                 take_miss;
    logic                 fill_now;
    logic                 alloc_now;
    logic                 unused_offset;

    assign req_tag       = req_addr[ADDR_W-1:OFF_W];
    assign unused_offset = ^req_addr[OFF_W-1:0];

    // Handshake and path selection for the current request.
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign cacheable = surf_ok && !req_uncached;
    assign take_hit  = accept && cacheable && cam_hit;
    assign take_miss = accept && !take_hit;
    assign fill_now  = (state_q == ST_WAIT) && mem_rsp_valid;
    assign alloc_now = fill_now && pend_alloc_q;

    tl1_surf_gate #(
        .NUM_SURF (NUM_SURF),
        .SURF_W   (SURF_W)
    ) i_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .done_valid_i (surf_done_valid),
        .done_id_i    (surf_done_id),
        .query_id_i   (req_surf),
        .ready_o      (surf_ok)
    );

    tl1_tag_cam #(
        .LINES (LINES),
        .TAG_W (TAG_W),
        .IDX_W (IDX_W)
    ) i_cam (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush),
        .lookup_tag_i (req_tag),
        .hit_o        (cam_hit),
        .hit_idx_o    (hit_idx),
        .alloc_en_i   (alloc_now),
        .alloc_tag_i  (pend_tag_q),
        .alloc_idx_o  (fill_idx)
    );

    tl1_line_store #(
        .LINES  (LINES),
        .LINE_W (LINE_BITS),
        .IDX_W  (IDX_W)
    ) i_store (
        .clk       (clk),
        .wr_en_i   (alloc_now),
        .wr_idx_i  (fill_idx),
        .wr_data_i (mem_rsp_data),
        .rd_idx_i  (hit_idx),
        .rd_data_o (store_rd)
    );

    // Miss sequencer: idle -> issue one request -> wait for the fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (take_miss) state_q <= ST_ISSUE;
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT:  if (mem_rsp_valid) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Remember the missed line and whether it may be allocated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_tag_q   <= '0;
            pend_alloc_q <= 1'b0;
        end else if (take_miss) begin
            pend_tag_q   <= req_tag;
            pend_alloc_q <= cacheable;
        end
    end

    // Response register: stored line on a hit, returned line on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= take_hit || fill_now;
            if (take_hit)      rsp_data_q <= store_rd;
            else if (fill_now) rsp_data_q <= mem_rsp_data;
        end
    end

    assign rsp_valid     = rsp_valid_q;
    assign rsp_data      = rsp_data_q;
    assign mem_req_valid = (state_q == ST_ISSUE);
    assign mem_req_addr  = {pend_tag_q, {OFF_W{1'b0}}};

    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rsp_valid))); // R2

    AST_MEMREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid); // R11

    AST_BUSY_DURING_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R3

    AST_UNCACHED_FETCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_uncached) |=> mem_req_valid); // R5

endmodule

// File: tb/test_tex_l1_cache.sv
`timescale 1ns/1ps
module test_tex_l1_cache;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_ready;
    logic [31:0]  req_addr;
    logic         req_uncached;
    logic [2:0]   req_surf;
    logic         rsp_valid;
    logic [255:0] rsp_data;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         mem_rsp_valid;
    logic [255:0] mem_rsp_data;
    logic         surf_done_valid;
    logic [2:0]   surf_done_id;
    logic         flush;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;
    logic [31:0] version = 32'h0;

    always #10 clk = ~clk;   // 50 MHz

    tex_l1_cache i_tex_l1_cache (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_addr        (req_addr),
        .req_uncached    (req_uncached),
        .req_surf        (req_surf),
        .rsp_valid       (rsp_valid),
        .rsp_data        (rsp_data),
        .mem_req_valid   (mem_req_valid),
        .mem_req_addr    (mem_req_addr),
        .mem_rsp_valid   (mem_rsp_valid),
        .mem_rsp_data    (mem_rsp_data),
        .surf_done_valid (surf_done_valid),
        .surf_done_id    (surf_done_id),
        .flush           (flush)
    );

    // Watchdog: a hung run is counted as a failure and still summarised.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // Lower-level line contents, distinct per line and per version.
    function automatic logic [255:0] line_pattern(input logic [31:0] line, input logic [31:0] ver);
        logic [255:0] v;
        for (int k = 0; k < 8; k++)
            v[k*32 +: 32] = (line * 32'h9E37_79B9) ^ (32'(k) << 28) ^ ver ^ 32'h5A5A_0000;
        return v;
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [255:0] act, input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    // One read; exp_hit selects the hit or miss timing; checks every cycle.
    task automatic read_line(input logic [31:0] addr, input logic unc, input logic [2:0] surf,
                             input bit exp_hit, input logic [255:0] exp_data, input string rq);
        logic [31:0] line_addr;
        line_addr = {addr[31:5], 5'b0};
        chk(req_ready === 1'b1, {rq, " ready before request"}, 256'(req_ready), 256'(1));
        req_valid = 1'b1; req_addr = addr; req_uncached = unc; req_surf = surf;
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_hit) begin
            chk(rsp_valid === 1'b1, {rq, " hit rsp_valid"}, 256'(rsp_valid), 256'(1));
            chk(rsp_data === exp_data, {rq, " hit data"}, rsp_data, exp_data);
            chk(mem_req_valid === 1'b0, {rq, " hit makes no fetch"}, 256'(mem_req_valid), 256'(0));
        end else begin
            chk(rsp_valid === 1'b0, {rq, " miss no early rsp"}, 256'(rsp_valid), 256'(0));
            chk(mem_req_valid === 1'b1, {rq, " R3 miss fetch"}, 256'(mem_req_valid), 256'(1));
            chk(mem_req_addr === line_addr, {rq, " R3 aligned addr"}, 256'(mem_req_addr), 256'(line_addr));
            chk(req_ready === 1'b0, {rq, " R3 busy"}, 256'(req_ready), 256'(0));
            @(negedge clk);
            chk(mem_req_valid === 1'b0, {rq, " R11 single request"}, 256'(mem_req_valid), 256'(0));
            chk(req_ready === 1'b0, {rq, " R11 no accept while waiting"}, 256'(req_ready), 256'(0));
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = exp_data;
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            chk(rsp_valid === 1'b1, {rq, " R4 fill rsp_valid"}, 256'(rsp_valid), 256'(1));
            chk(rsp_data === exp_data, {rq, " R4 fill data"}, rsp_data, exp_data);
            chk(req_ready === 1'b1, {rq, " R3 ready after fill"}, 256'(req_ready), 256'(1));
        end
    endtask

    task automatic pulse_done(input logic [2:0] id);
        surf_done_valid = 1'b1; surf_done_id = id;
        @(negedge clk);
        surf_done_valid = 1'b0;
    endtask

    task automatic pulse_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        chk(req_ready === 1'b1, "R1 ready after reset", 256'(req_ready), 256'(1));
        chk(rsp_valid === 1'b0, "R1 rsp_valid after reset", 256'(rsp_valid), 256'(0));
        chk(mem_req_valid === 1'b0, "R1 mem_req_valid after reset", 256'(mem_req_valid), 256'(0));
    endtask

    // R6: uncompleted surface never allocates; after the pulse it does.
    task automatic t_gate();
        logic [31:0] a;
        a = 32'h0001_2340;
        pulse_done(3'd1);                          // surface 1 only
        read_line(a, 1'b0, 3'd2, 1'b0, line_pattern(a >> 5, version), "R6 gated read 1");
        read_line(a, 1'b0, 3'd2, 1'b0, line_pattern(a >> 5, version), "R6 gated read 2 no alloc");
        pulse_done(3'd2);
        read_line(a, 1'b0, 3'd2, 1'b0, line_pattern(a >> 5, version), "R1 R6 first cacheable miss");
        read_line(a, 1'b0, 3'd2, 1'b1, line_pattern(a >> 5, version), "R2 R4 R6 hit after alloc");
    endtask

    // R10: another byte offset of the same line hits the same entry.
    task automatic t_offset();
        logic [31:0] a;
        a = 32'h0001_2340;
        read_line(a + 32'd31, 1'b0, 3'd2, 1'b1, line_pattern(a >> 5, version), "R10 offset 31 hit");
        read_line(a + 32'd7,  1'b0, 3'd1, 1'b1, line_pattern(a >> 5, version), "R10 offset 7 other surface");
    endtask

    // R5: uncached read fetches new data and leaves the stale entry alone.
    task automatic t_uncached();
        logic [31:0] a;
        logic [31:0] old_ver;
        a = 32'h0001_2340;
        old_ver = version;
        version = version + 32'h100;
        read_line(a, 1'b1, 3'd2, 1'b0, line_pattern(a >> 5, version), "R5 uncached fetches");
        read_line(a, 1'b0, 3'd2, 1'b1, line_pattern(a >> 5, old_ver), "R5 uncached did not allocate");
        read_line(32'h0077_0000, 1'b1, 3'd2, 1'b0, line_pattern(32'h0077_0000 >> 5, version), "R5 uncached new line");
        read_line(32'h0077_0000, 1'b1, 3'd2, 1'b0, line_pattern(32'h0077_0000 >> 5, version), "R5 uncached never hits");
    endtask

    // R9: flush invalidates all lines but keeps surfaces cacheable.
    task automatic t_flush();
        logic [31:0] a;
        a = 32'h0001_2340;
        pulse_flush();
        read_line(a, 1'b0, 3'd2, 1'b0, line_pattern(a >> 5, version), "R9 miss after flush");
        read_line(a, 1'b0, 3'd2, 1'b1, line_pattern(a >> 5, version), "R9 surface still cacheable");
    endtask

    function automatic logic [31:0] cap_addr(input int i);
        return (32'(i) * 32'h0001_0003) << 5;
    endfunction

    // R7 and R8: fill every entry, re-hit all, then trace round-robin eviction.
    task automatic t_capacity_replace();
        logic [31:0] b;
        pulse_flush();
        for (int i = 0; i < 256; i++)
            read_line(cap_addr(i), 1'b0, 3'd1, 1'b0, line_pattern(cap_addr(i) >> 5, version), "R7 fill");
        for (int i = 0; i < 256; i++)
            read_line(cap_addr(i) + 32'd4, 1'b0, 3'd1, 1'b1, line_pattern(cap_addr(i) >> 5, version), "R7 all resident");
        b = 32'hFFFF_FFE0;
        read_line(b, 1'b0, 3'd1, 1'b0, line_pattern(b >> 5, version), "R8 new line evicts entry 0");
        read_line(b, 1'b0, 3'd1, 1'b1, line_pattern(b >> 5, version), "R8 new line resident");
        read_line(cap_addr(1), 1'b0, 3'd1, 1'b1, line_pattern(cap_addr(1) >> 5, version), "R8 entry 1 kept");
        read_line(cap_addr(0), 1'b0, 3'd1, 1'b0, line_pattern(cap_addr(0) >> 5, version), "R8 entry 0 was victim");
        read_line(cap_addr(2), 1'b0, 3'd1, 1'b1, line_pattern(cap_addr(2) >> 5, version), "R8 entry 2 kept");
        read_line(cap_addr(1), 1'b0, 3'd1, 1'b0, line_pattern(cap_addr(1) >> 5, version), "R8 entry 1 was victim");
        read_line(cap_addr(3), 1'b0, 3'd1, 1'b1, line_pattern(cap_addr(3) >> 5, version), "R8 entry 3 kept");
        read_line(cap_addr(2), 1'b0, 3'd1, 1'b0, line_pattern(cap_addr(2) >> 5, version), "R8 entry 2 was victim");
    endtask

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b0; req_addr = '0; req_uncached = 1'b0; req_surf = '0;
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        surf_done_valid = 1'b0; surf_done_id = '0; flush = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate();
        t_offset();
        t_uncached();
        t_flush();
        t_capacity_replace();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule